// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat of one SDRAM burst. A command is launched with a start or restart strobe. Together with the strobe come a starting column address, a burst length code and a burst type. From that cycle on the block presents one column address per clock. It raises a last-beat flag on the final beat and a busy flag while beats remain to be delivered. The first address appears combinationally in the launch cycle, so write data that arrives with the command lines up with its column.

A new command arriving mid-burst discards the remaining addresses and starts a burst of the full programmed length from its own address. A full-page burst never ends by itself: it walks every column with modulo wrap until a stop or a new command arrives. A stop is accepted only while a full-page burst is running. Any other stop is reported on an error flag and otherwise ignored. Cell array access, CAS latency delay and data masking belong to neighbouring logic.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The length code `blen_i` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page (256 columns). Codes 4, 5 and 6 behave as a single beat.
- R2: On a launch cycle (`start_i` or `restart_i` high), `col_o` equals `col_i` with `valid_o` high in that same cycle. Beat k follows k clock cycles later, one beat per cycle.
- R3: In sequential mode (`btype_i`=0), beat k is the start address with its low log2(length) bits replaced by (start+k) modulo the length. The bits above that window never change.
- R4: In interleave mode (`btype_i`=1), beat k is the start address with its low log2(length) bits XORed with k.
- R5: A full-page burst counts upward modulo 256 with no end of its own. Interleave with full page behaves as sequential.
- R6: `last_o` is high on the final beat only, which is the launch cycle for a single-beat burst. In the cycle after it, `valid_o` and `busy_o` are low unless a new launch arrives, so later data has no column.
- R7: A launch during a burst replaces the remaining beats in that cycle and delivers a burst of the full new length from the new address.
- R8: `stop_i` during a full-page burst with no launch ends the burst. No beat is output in that cycle (`valid_o` low), and `busy_o` is low afterwards.
- R9: `stop_i` at any other time without a launch raises `stop_illegal_o` in that cycle and leaves the address sequence unchanged.
- R10: `busy_o` is high in the cycles after a launch while beats remain. A synchronous low `rst_n` clears it, and after reset all outputs are low with idle inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launch a new burst |
| restart_i | input | 1 | Interrupting command, launches a new burst |
| stop_i | input | 1 | Burst stop request |
| col_i | input | 8 | Starting column address |
| blen_i | input | 3 | Burst length code |
| btype_i | input | 1 | 0 sequential, 1 interleave |
| col_o | output | 8 | Column address of the current beat (0 when not valid) |
| valid_o | output | 1 | A beat is output this cycle |
| last_o | output | 1 | This beat is the final one |
| busy_o | output | 1 | Beats remain from an earlier launch |
| stop_illegal_o | output | 1 | Stop request was not accepted |

## Verification
Fixed-length bursts are run from start addresses near the top of their window, such as 0xFD with eight beats and 0x2D with four. Those starts show whether the wrap stays inside the window or carries into higher bits. The same starts are used in both burst types, so the two orders can be told apart. A full-page burst from 0xFE runs past 256 beats, which checks the modulo wrap and that it never flags a last beat. The interrupt tests use both strobes, one in the middle of an eight-beat burst and one during a full-page run. A stop given during a four-beat burst and another given while idle show the difference between an accepted stop and a rejected one.

// File: rtl/colgen_pkg.sv
// Shared constants and types for the burst column address generator.
// Assumes a 3-bit burst length code; fixed lengths are powers of two up to 8.
package colgen_pkg;
    localparam int          LEN_CODE_W    = 3;
    localparam logic [2:0]  LEN_CODE_PAGE = 3'd7;
    localparam int          MAX_FIXED_LOG = 3;

    typedef enum logic {
        BT_SEQ = 1'b0,
        BT_ILV = 1'b1
    } btype_e;
endpackage

// File: rtl/colgen_len_dec.sv
// Length decoder: turns a burst length code into a window mask over the
// column bits that change during the burst, plus a full-page flag.
// Assumes reserved codes act as a single beat (empty mask).
module colgen_len_dec #(
    parameter int COL_W  = 8,
    parameter int CODE_W = colgen_pkg::LEN_CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              full_o
);
    logic [CODE_W-1:0] win_log;

    // Full-page code and the window width for fixed lengths.
    always_comb begin
        full_o  = (code_i == CODE_W'(colgen_pkg::LEN_CODE_PAGE));
        win_log = (int'(code_i) <= colgen_pkg::MAX_FIXED_LOG) ? code_i : '0;
    end

    // One mask bit per column bit: set when inside the burst window.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = full_o | (int'(win_log) > i);
    end
endmodule

// File: rtl/colgen_addr.sv
// Address formatter: combinational column of beat k for a given base,
// window mask and order. Bits outside the mask are taken from the base.
module colgen_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] addr_o
);
    logic [COL_W-1:0] sum;

    // Interleave flips low bits by the beat index; sequential wraps a sum.
    always_comb begin
        sum = base_i + beat_i;
        if (ilv_i) addr_o = base_i ^ (beat_i & mask_i);
        else       addr_o = (base_i & ~mask_i) | (sum & mask_i);
    end
endmodule

// File: rtl/colgen_seq.sv
// Burst sequencer: holds the launched burst parameters and the beat index,
// and tracks whether beats remain. A launch always wins over stop.
module colgen_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o,
    output logic             ilv_o,
    output logic             busy_o,
    output logic             stop_ok_o
);
    // Stop is taken only during a running full-page burst.
    assign stop_ok_o = stop_i & ~launch_i & busy_o & full_o;

    // Load on launch, else advance the beat index until the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            beat_o <= '0;
            mask_o <= '0;
            full_o <= 1'b0;
            ilv_o  <= 1'b0;
            busy_o <= 1'b0;
        end else if (launch_i) begin
            base_o <= col_i;
            beat_o <= COL_W'(1);
            mask_o <= mask_i;
            full_o <= full_i;
            ilv_o  <= ilv_i & ~full_i;
            busy_o <= (mask_i != '0);
        end else if (busy_o) begin
            if (stop_ok_o) begin
                busy_o <= 1'b0;
            end else begin
                beat_o <= beat_o + COL_W'(1);
                if (!full_o && beat_o == mask_o) busy_o <= 1'b0;
            end
        end
    end

    // R6
    beat_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !full_o) |-> (beat_o <= mask_o));
endmodule

// File: rtl/sdram_burst_colgen.sv
// Top of the burst column address generator. Selects live command fields
// in a launch cycle and held state otherwise, so the first column appears
// with the command. Assumes a launch is a single-cycle strobe per command.
module sdram_burst_colgen #(
    parameter int COL_W  = 8,
    parameter int CODE_W = colgen_pkg::LEN_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              restart_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [CODE_W-1:0] blen_i,
    input  logic              btype_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              stop_illegal_o
);
    import colgen_pkg::*;

    btype_e           bt;
    logic             launch;
    logic [COL_W-1:0] in_mask;
    logic             in_full;
    logic [COL_W-1:0] base_r, beat_r, mask_r;
    logic             full_r, ilv_r, busy_r, stop_ok;
    logic [COL_W-1:0] sel_base, sel_beat, sel_mask;
    logic             sel_ilv;
    logic [COL_W-1:0] addr;

    assign bt     = btype_e'(btype_i);
    assign launch = start_i | restart_i;

    colgen_len_dec #(.COL_W(COL_W), .CODE_W(CODE_W)) u_dec (
        .code_i (blen_i),
        .mask_o (in_mask),
        .full_o (in_full)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .stop_i    (stop_i),
        .col_i     (col_i),
        .mask_i    (in_mask),
        .full_i    (in_full),
        .ilv_i     (bt == BT_ILV),
        .base_o    (base_r),
        .beat_o    (beat_r),
        .mask_o    (mask_r),
        .full_o    (full_r),
        .ilv_o     (ilv_r),
        .busy_o    (busy_r),
        .stop_ok_o (stop_ok)
    );

    // Beat 0 comes from the live inputs; later beats from held state.
    always_comb begin
        sel_base = launch ? col_i   : base_r;
        sel_beat = launch ? '0      : beat_r;
        sel_mask = launch ? in_mask : mask_r;
        sel_ilv  = launch ? ((bt == BT_ILV) & ~in_full) : ilv_r;
    end

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .base_i (sel_base),
        .beat_i (sel_beat),
        .mask_i (sel_mask),
        .ilv_i  (sel_ilv),
        .addr_o (addr)
    );

    // Output flags and the gated column.
    always_comb begin
        valid_o        = launch | (busy_r & ~stop_ok);
        last_o         = launch ? (in_mask == '0)
                                : (busy_r & ~full_r & (beat_r == mask_r));
        busy_o         = busy_r;
        stop_illegal_o = stop_i & ~launch & ~(busy_r & full_r);
        col_o          = valid_o ? addr : '0;
    end

    // R3
    high_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_r && !launch && !stop_ok) |-> ($countones((col_o ^ base_r) & ~mask_r) == 0));

    // R6
    last_has_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R6
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o);

    // R8
    stop_ends_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && busy_o && full_r && !launch) |=> !busy_o);

    // R5
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && full_r && !launch && !stop_i) |=>
        (start_i || restart_i || stop_i || (col_o == COL_W'($past(col_o) + 1'b1))));

    // R7
    launch_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy_o == $past(in_mask != '0)));
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i, restart_i, stop_i, btype_i;
    logic [7:0] col_i;
    logic [2:0] blen_i;
    logic [7:0] col_o;
    logic       valid_o, last_o, busy_o, stop_illegal_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen i_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
        .stop_i(stop_i), .col_i(col_i), .blen_i(blen_i), .btype_i(btype_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o),
        .stop_illegal_o(stop_illegal_o)
    );

    // {type, code, start column}
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h5A}, {1'b0, 3'd1, 8'h37}, {1'b0, 3'd2, 8'h2D},
        {1'b0, 3'd3, 8'hFD}, {1'b1, 3'd1, 8'h37}, {1'b1, 3'd2, 8'h2D},
        {1'b1, 3'd3, 8'h05}, {1'b0, 3'd3, 8'h05}, {1'b0, 3'd5, 8'h99},
        {1'b1, 3'd0, 8'h11}
    };

    function automatic int exp_len(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] b, input logic [2:0] code,
                                           input logic ty, input int k);
        logic [7:0] m;
        logic [7:0] kk;
        m  = 8'(exp_len(code) - 1);
        kk = 8'(k);
        if (code == 3'd7) return 8'(b + kk);
        if (ty) return b ^ (kk & m);
        return (b & ~m) | (8'(b + kk) & m);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic drive(input logic st, input logic rs, input logic sp,
                         input logic [7:0] c, input logic [2:0] code, input logic ty);
        @(negedge clk);
        start_i = st; restart_i = rs; stop_i = sp;
        col_i = c; blen_i = code; btype_i = ty;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
    endtask

    task automatic beat(input string req, input logic [7:0] ec, input logic el);
        chk(valid_o == 1'b1, req, "valid", valid_o, 1);
        chk(col_o == ec, req, "col", col_o, ec);
        chk(last_o == el, req, "last", last_o, el);
    endtask

    task automatic run_vec(input logic [11:0] v);
        logic       ty;
        logic [2:0] code;
        logic [7:0] c;
        int         n;
        ty = v[11]; code = v[10:8]; c = v[7:0]; n = exp_len(code);
        drive(1'b1, 1'b0, 1'b0, c, code, ty);
        beat("R2", c, n == 1);
        for (int k = 1; k < n; k++) begin
            idle();
            beat(ty ? "R4" : "R3", exp_col(c, code, ty, k), k == n - 1);
            chk(busy_o == 1'b1, "R10", "busy mid", busy_o, 1);
        end
        idle();
        chk(valid_o == 1'b0, "R6", "valid after last", valid_o, 0);
        chk(busy_o == 1'b0, "R1", "busy after length", busy_o, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start_i = 0; restart_i = 0; stop_i = 0; col_i = 0; blen_i = 0; btype_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R10 reset state
        chk(valid_o == 0 && busy_o == 0 && last_o == 0 && stop_illegal_o == 0,
            "R10", "reset outputs", {valid_o, busy_o, last_o, stop_illegal_o}, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R5 full page wraps past 0xFF, no last flag
        drive(1'b1, 1'b0, 1'b0, 8'hFE, 3'd7, 1'b0);
        beat("R5", 8'hFE, 1'b0);
        for (int k = 1; k < 260; k++) begin
            idle();
            beat("R5", 8'(8'hFE + k), 1'b0);
        end
        // R8 stop accepted
        drive(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0);
        chk(valid_o == 0, "R8", "valid in stop cycle", valid_o, 0);
        chk(stop_illegal_o == 0, "R8", "stop flagged", stop_illegal_o, 0);
        idle();
        chk(busy_o == 0 && valid_o == 0, "R8", "busy after stop", busy_o, 0);

        // R5 interleave with full page runs sequential; R7 start interrupts
        drive(1'b1, 1'b0, 1'b0, 8'h10, 3'd7, 1'b1);
        beat("R5", 8'h10, 1'b0);
        for (int k = 1; k < 4; k++) begin
            idle();
            beat("R5", 8'(8'h10 + k), 1'b0);
        end
        drive(1'b1, 1'b0, 1'b0, 8'h42, 3'd2, 1'b0);
        beat("R7", 8'h42, 1'b0);
        idle(); beat("R7", 8'h43, 1'b0);
        idle(); beat("R7", 8'h40, 1'b0);
        idle(); beat("R7", 8'h41, 1'b1);
        idle();
        chk(busy_o == 0, "R7", "busy after page interrupt", busy_o, 0);

        // R7 restart mid eight-beat burst gives full new length
        drive(1'b1, 1'b0, 1'b0, 8'h0C, 3'd3, 1'b0);
        beat("R7", 8'h0C, 1'b0);
        idle(); beat("R7", 8'h0D, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 8'h23, 3'd3, 1'b0);
        beat("R7", 8'h23, 1'b0);
        for (int k = 1; k < 8; k++) begin
            idle();
            beat("R7", exp_col(8'h23, 3'd3, 1'b0, k), k == 7);
        end
        idle();
        chk(valid_o == 0, "R7", "valid after restarted burst", valid_o, 0);

        // R9 stop during a four-beat burst is flagged and ignored
        drive(1'b1, 1'b0, 1'b0, 8'h01, 3'd2, 1'b0);
        beat("R9", 8'h01, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0);
        chk(stop_illegal_o == 1, "R9", "flag", stop_illegal_o, 1);
        beat("R9", 8'h02, 1'b0);
        idle(); beat("R9", 8'h03, 1'b0);
        chk(stop_illegal_o == 0, "R9", "flag cleared", stop_illegal_o, 0);
        idle(); beat("R9", 8'h00, 1'b1);
        // R9 stop while idle
        drive(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0);
        chk(stop_illegal_o == 1 && valid_o == 0, "R9", "idle stop",
            {stop_illegal_o, valid_o}, 2);

        // R10 reset in the middle of a burst clears busy
        drive(1'b1, 1'b0, 1'b0, 8'h80, 3'd3, 1'b0);
        idle();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk(busy_o == 0 && valid_o == 0, "R10", "busy after reset", busy_o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule